// File: doc/BRIEF.md
# Byte-Multiplexed Conversion Result Read Port

This block returns a 12-bit conversion result to a host over an 8-bit data bus in two reads. The host pulls chip select low and strobes the active-low read line. A high-byte select input chooses which half of the result is driven. With the select low, the bus carries the lower eight result bits. With the select high, the low nibble carries the four most significant bits. The upper nibble of that high byte is filled according to the coding in force. Unipolar results are straight binary, so their fill is zero. Bipolar results are two's complement, so their fill copies the sign bit. This lets a host treat the high byte directly as a signed or unsigned value.

The port produces a data value and a separate output enable, which the pad ring turns into a three-state driver. It also issues a one-clock request that tells the conversion logic to release its completion flag. That request fires only on the first read strobe of a chip-select span, so fetching the second byte does not raise it again. All inputs are treated as synchronous to the block clock.

Top module: `result_byte_port`

## Requirements
- R1: With `hiSel` = 0 and the bus enabled, `busData[7:0]` equals `resultIn[7:0]`.
- R2: With `hiSel` = 1 and the bus enabled, `busData[3:0]` equals `resultIn[11:8]`.
- R3: With `hiSel` = 1, `bipolar` = 1 and the bus enabled, each of `busData[7:4]` equals `resultIn[11]`.
- R4: With `hiSel` = 1, `bipolar` = 0 and the bus enabled, `busData[7:4]` is 0.
- R5: `busOe` is 1 in exactly the cycles where `csN` = 0 and `rdN` = 0. It follows both inputs combinationally, so it drops in the same cycle `rdN` returns high.
- R6: While `csN` = 1, `busOe` is 0 and a falling edge on `rdN` produces no `clrReq` pulse.
- R7: After a clock edge that samples `rdN` low with `csN` low, where the previous sample of `rdN` was high (or reset preceded it), `clrReq` is 1 for exactly one cycle.
- R8: Once a pulse has been issued, further `rdN` falling edges before `csN` returns high produce no `clrReq` pulse. A new chip-select span rearms the request.
- R9: While `busOe` = 0, `busData` is 0. During and after reset `clrReq` is 0 until a qualifying read edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| hiSel | input | 1 | 1 selects the high byte, 0 the low byte |
| resultIn | input | 12 | Stored conversion result |
| bipolar | input | 1 | 1 for two's complement coding, 0 for straight binary |
| busData | output | 8 | Data value for the bus driver |
| busOe | output | 1 | Output enable for the bus driver |
| clrReq | output | 1 | One-cycle request to release the completion flag |

## Verification
The bench looks at the high byte with the sign bit set and clear under both codings. A design that sign-extended unconditionally would show 0xF in the fill of a unipolar result at or above half scale. A design that zero-filled would corrupt negative bipolar values. It strobes read several times within one chip-select span, strobes read with chip select high, and toggles the byte select while read is held low. In these cases a faulty edge detector would raise a second clear or a spurious one. It also checks that the enable drops in the very cycle read rises, which catches a registered enable that holds the bus one cycle too long.

// File: rtl/result_byte_port_pkg.sv
`timescale 1ns/1ps
package result_byte_port_pkg;

  // Strobes passed from the read control to the byte datapath
  typedef struct packed {
    logic drive;   // bus is being read this cycle
    logic hiByte;  // high half selected
  } portStrobe_t;

endpackage

// File: rtl/result_byte_port_ctrl.sv
`timescale 1ns/1ps
module result_byte_port_ctrl
  import result_byte_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        hiSel,
  output portStrobe_t strobe,
  output logic        clrReq
);

  logic rdPrev;      // last sampled read level
  logic spanDone;    // a clear already issued in this chip-select span
  logic rdFall;

  assign rdFall = rdPrev & ~rdN & ~csN;

  always_comb begin
    strobe.drive  = ~csN & ~rdN;
    strobe.hiByte = hiSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev   <= 1'b1;
      spanDone <= 1'b0;
      clrReq   <= 1'b0;
    end else begin
      rdPrev <= rdN;
      clrReq <= rdFall & ~spanDone;
      if (csN)
        spanDone <= 1'b0;
      else if (rdFall)
        spanDone <= 1'b1;
    end
  end

endmodule

// File: rtl/result_byte_port_dp.sv
`timescale 1ns/1ps
module result_byte_port_dp
  import result_byte_port_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
)(
  input  portStrobe_t      strobe,
  input  logic [RES_W-1:0] resultIn,
  input  logic             bipolar,
  output logic [BUS_W-1:0] busData,
  output logic             busOe
);

  localparam int HI_W   = RES_W - BUS_W;
  localparam int FILL_W = BUS_W - HI_W;

  logic [BUS_W-1:0] hiWord;
  logic [BUS_W-1:0] loWord;
  logic             fillBit;

  assign fillBit = bipolar & resultIn[RES_W-1];
  assign loWord  = resultIn[BUS_W-1:0];
  assign hiWord[HI_W-1:0] = resultIn[RES_W-1:BUS_W];

  generate
    if (FILL_W > 0) begin : g_fill
      for (genvar i = HI_W; i < BUS_W; i++) begin : g_bit
        assign hiWord[i] = fillBit;
      end
    end
  endgenerate

  always_comb begin
    busOe = strobe.drive;
    if (!strobe.drive)
      busData = '0;
    else if (strobe.hiByte)
      busData = hiWord;
    else
      busData = loWord;
  end

endmodule

// File: rtl/result_byte_port.sv
`timescale 1ns/1ps
module result_byte_port
  import result_byte_port_pkg::*;
#(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rdN,
  input  logic             hiSel,
  input  logic [RES_W-1:0] resultIn,
  input  logic             bipolar,
  output logic [BUS_W-1:0] busData,
  output logic             busOe,
  output logic             clrReq
);

  portStrobe_t strobe;

  result_byte_port_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csN    (csN),
    .rdN    (rdN),
    .hiSel  (hiSel),
    .strobe (strobe),
    .clrReq (clrReq)
  );

  result_byte_port_dp #(.RES_W(RES_W), .BUS_W(BUS_W)) u_dp (
    .strobe   (strobe),
    .resultIn (resultIn),
    .bipolar  (bipolar),
    .busData  (busData),
    .busOe    (busOe)
  );

endmodule

// File: rtl/result_byte_port_chk.sv
`timescale 1ns/1ps
module result_byte_port_chk #(
  parameter int RES_W = 12,
  parameter int BUS_W = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rdN,
  input logic             hiSel,
  input logic [RES_W-1:0] resultIn,
  input logic             bipolar,
  input logic [BUS_W-1:0] busData,
  input logic             busOe,
  input logic             clrReq
);

  localparam int HI_W = RES_W - BUS_W;

  logic pulsedInSpan;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pulsedInSpan <= 1'b0;
    else if (csN)     pulsedInSpan <= 1'b0;
    else if (clrReq)  pulsedInSpan <= 1'b1;
  end

  p_low_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && !hiSel) |-> busData == resultIn[BUS_W-1:0]);

  p_high_nibble_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && hiSel) |-> busData[HI_W-1:0] == resultIn[RES_W-1:BUS_W]);

  p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && hiSel && bipolar) |->
      busData[BUS_W-1:HI_W] == {(BUS_W-HI_W){resultIn[RES_W-1]}});

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && hiSel && !bipolar) |-> busData[BUS_W-1:HI_W] == '0);

  p_oe_follows_rd_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdN |-> !busOe);

  p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !clrReq);

  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> !clrReq);

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |-> $past(!rdN && !csN));

  p_single_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |-> !pulsedInSpan);

  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busOe |-> busData == '0);

endmodule

bind result_byte_port result_byte_port_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .rdN      (rdN),
  .hiSel    (hiSel),
  .resultIn (resultIn),
  .bipolar  (bipolar),
  .busData  (busData),
  .busOe    (busOe),
  .clrReq   (clrReq)
);

// File: tb/tb_result_byte_port.sv
`timescale 1ns/1ps
module tb_result_byte_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        rdN = 1'b1;
  logic        hiSel = 1'b0;
  logic [11:0] resultIn = '0;
  logic        bipolar = 1'b0;
  logic [7:0]  busData;
  logic        busOe;
  logic        clrReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  result_byte_port dut (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .hiSel(hiSel),
    .resultIn(resultIn), .bipolar(bipolar),
    .busData(busData), .busOe(busOe), .clrReq(clrReq)
  );

  // Behavioural reference for the clear request
  int    refPrevRd;
  int    refSpanPulses;
  int    expClr;
  string clrTag;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPrevRd     = 1;
      refSpanPulses = 0;
      expClr        = 0;
      clrTag        = "R9";
    end else begin
      if (csN) clrTag = "R6";
      else if (refSpanPulses > 0) clrTag = "R8";
      else clrTag = "R7";
      expClr = (refPrevRd == 1 && rdN == 1'b0 && csN == 1'b0 && refSpanPulses == 0) ? 1 : 0;
      if (csN) refSpanPulses = 0;
      else if (expClr == 1) refSpanPulses = refSpanPulses + 1;
      refPrevRd = rdN ? 1 : 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int expOe;
    int hiNib;
    int fill;
    expOe = (!csN && !rdN) ? 1 : 0;
    check(csN ? "R6" : "R5", busOe, expOe);
    if (expOe == 0) begin
      check("R9", busData, 0);
    end else if (!hiSel) begin
      check("R1", busData, resultIn & 12'h0FF);
    end else begin
      hiNib = resultIn >> 8;
      fill  = (bipolar && resultIn >= 12'd2048) ? 15 : 0;
      check("R2", busData & 8'h0F, hiNib);
      check(bipolar ? "R3" : "R4", busData >> 4, fill);
    end
    check(clrTag, clrReq, expClr);
  endtask

  task automatic step(input logic c, input logic r, input logic h);
    @(negedge clk);
    csN = c; rdN = r; hiSel = h;
    #1;
    compareAll();
  endtask

  task automatic readBoth(input logic [11:0] res, input logic bip);
    @(negedge clk);
    resultIn = res; bipolar = bip;
    step(0, 1, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 1, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    step(0, 1, 1);
    step(1, 1, 0);
    step(1, 1, 0);
  endtask

  initial begin
    // reset state (R9)
    step(1, 1, 0);
    step(1, 1, 0);
    @(negedge clk); rstN = 1'b1;
    step(1, 1, 0);

    // both codings, sign set and clear (R1..R4, R7, R8)
    readBoth(12'hA5C, 1'b1);
    readBoth(12'h7F3, 1'b1);
    readBoth(12'h800, 1'b0);
    readBoth(12'hFFF, 1'b0);
    readBoth(12'h000, 1'b1);
    readBoth(12'h3C9, 1'b0);

    // read strobes with chip select high (R6)
    resultIn = 12'h9E1; bipolar = 1'b1;
    step(1, 0, 0);
    step(1, 1, 0);
    step(1, 0, 1);
    step(1, 1, 1);

    // select toggled while read held low, then repeated strobes (R8)
    step(0, 0, 0);
    step(0, 0, 1);
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 0, 1);
    step(0, 1, 1);
    step(0, 0, 0);
    step(0, 1, 0);
    // chip select drops mid-read and returns: new span rearms (R5, R8)
    step(1, 0, 0);
    step(0, 0, 0);
    step(0, 1, 0);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      if (i % 97 == 0) begin
        resultIn = 12'($urandom);
        bipolar  = 1'($urandom);
      end
      step(1'(($urandom % 4) == 0), 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule